// File: doc/BRIEF.md
# Short-Flit Pairing Switch Allocator

This block is the switch allocation stage of a five-port router with several virtual channels (VCs) per input port. Each cycle it decides which flits cross the crossbar. It is a separable allocator with two stages. In the first stage, every input port picks one of its VCs in round-robin order. In the second stage, every output port picks one of the input ports that target it, also in round-robin order.

A flit narrow enough to fill half of the channel is called short. Two short flits can share one output in the same cycle, in either of two ways:

- Two VCs of the same input port that hold short flits for the same output form a single paired request in stage 1. If that request wins stage 2, both flits cross together.
- A second round-robin arbiter at each output sees only single short requests. When the primary winner is a single short flit, this arbiter supplies a short flit from another input port to fill the lower half.

The outputs are half-select controls for the crossbar: the upper half comes from a (port, VC) pair and the lower half from another. A grant vector, one bit per input VC, tells each VC that its flit leaves. Outputs are combinational from the current requests and the registered priority pointers. The pointers change at the clock edge.

Top module: `sa_pair_alloc`

## Requirements
- R1: Each input port picks the first eligible VC at or after its stage-1 pointer, in cyclic order. When that pick is granted, the pointer moves to the VC after the picked one.
- R2: The stage-1 pick may be short, and another eligible VC of the same port may also be short with the same destination. In that case the two form one paired request: the upper half carries the picked VC and the lower half the partner from the same port. Of several possible partners, the first one after the picked VC in cyclic order is used. Both flits are granted.
- R3: Each output grants its upper half to the first requesting input at or after its primary pointer. After any grant, the pointer moves to the input after the winner.
- R4: A primary winner that is a single short flit gets a lower-half partner from the secondary arbiter. That arbiter takes the first other input, at or after its own pointer, whose stage-1 pick is a single short flit for this output. It never takes the primary winner. Its pointer moves past the partner only when the partner is used.
- R5: A long flit takes the whole output: `out_full` is 1, no lower half is granted, and short requests from other inputs wait.
- R6: No flit is granted twice in a cycle. The lower half never names the same (port, VC) as the upper half.
- R7: A pointer stays unchanged in any cycle where its choice is not granted. An input that loses stage 2 offers the same VC in the next cycle.
- R8: Reset sets every pointer to index 0. With no requests, no output is busy and no grant bit is set.
- R9: Bit `i*NVC+v` of `vc_grant` is set exactly when VC v of input i has a flit granted in that cycle. It is never set for a VC without a valid request.
- R10: A request whose destination is 5 or above is ignored, and the port's other VCs compete as if it were absent. Destinations are encoded as 0 north, 1 south, 2 east, 3 west, 4 local.
- R11: An output grants only to inputs whose stage-1 pick targets it. Each input is granted by at most one output per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5*NVC | Request valid per input VC, index i*NVC+v |
| in_dest | input | 5*NVC*3 | Destination output per input VC |
| in_short | input | 5*NVC | Flit at this VC is short (fits half the channel) |
| vc_grant | output | 5*NVC | Flit of this input VC is granted this cycle |
| out_busy | output | 5 | Output has an upper-half grant |
| out_full | output | 5 | Upper-half flit is long and uses the whole output |
| out_hi_port | output | 5*3 | Input port feeding the upper half |
| out_hi_vc | output | 5*VCW | VC feeding the upper half |
| out_lo_valid | output | 5 | Lower half is in use |
| out_lo_port | output | 5*3 | Input port feeding the lower half |
| out_lo_vc | output | 5*VCW | VC feeding the lower half |

## Verification
Properties are checked on every cycle:

- a long winner never has a lower half;
- the lower half never repeats the upper-half flit;
- a lower half from another port pairs two single short flits;
- grants appear only on requesting VCs;
- an output grants only a requester that targets it;
- each pointer holds when its choice is not granted.

Only the directed scenarios can show that round-robin order is actually fair. These scenarios cover rotation over five cycles, the secondary arbiter wrapping past the primary winner, and a losing input keeping its VC. The same holds for the exact partner chosen and for the sweep over every single request to every output.

// File: rtl/sa_pkg.sv
package sa_pkg;

    // Router radix and destination encoding width
    localparam int SA_NPORT = 5;
    localparam int SA_PW    = 3;

    // Output port numbering (destination field values)
    typedef enum logic [SA_PW-1:0] {
        PORT_NORTH = 3'd0,
        PORT_SOUTH = 3'd1,
        PORT_EAST  = 3'd2,
        PORT_WEST  = 3'd3,
        PORT_LOCAL = 3'd4
    } port_e;

    // Kind of request an input offers to stage 2
    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_LONG  = 2'd1,
        K_SHORT = 2'd2,
        K_PAIR  = 2'd3
    } req_kind_e;

    // Stage-1 result of one input port
    typedef struct packed {
        req_kind_e         kind;
        logic [SA_PW-1:0]  dest;
    } s1_req_t;

    function automatic logic is_valid_dest(logic [SA_PW-1:0] d);
        return int'(d) < SA_NPORT;
    endfunction

endpackage

// File: rtl/sa_rr_pick.sv
// Combinational round-robin pick: first set request at or after ptr.
module sa_rr_pick #(
    parameter int N  = 5,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    localparam int CW = IW + 1;

    logic [CW-1:0] cand;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        cand  = '0;
        for (int k = 0; k < N; k++) begin
            cand = {1'b0, ptr} + CW'(k);
            if (cand >= CW'(N)) begin
                cand = cand - CW'(N);
            end
            if (!found && req[cand[IW-1:0]]) begin
                found = 1'b1;
                idx   = cand[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/sa_input_stage.sv
// Stage 1: per-input VC arbiter with same-port short-flit pairing.
module sa_input_stage
    import sa_pkg::*;
#(
    parameter int NVC = 2,
    parameter int VCW = (NVC > 1) ? $clog2(NVC) : 1,
    parameter int PW  = SA_PW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NVC-1:0]     vc_valid,
    input  logic [NVC*PW-1:0]  vc_dest,
    input  logic [NVC-1:0]     vc_short,
    input  logic               granted,
    output s1_req_t            req,
    output logic [VCW-1:0]     vc_a,
    output logic [VCW-1:0]     vc_b
);
    logic [PW-1:0]  dest_of [NVC];
    logic [NVC-1:0] eligible;
    logic [NVC-1:0] partner_mask;
    logic [VCW-1:0] ptr_q;
    logic [VCW-1:0] a_next;
    logic           first_found;
    logic           partner_found;

    always_comb begin
        for (int v = 0; v < NVC; v++) begin
            dest_of[v]  = vc_dest[v*PW +: PW];
            eligible[v] = vc_valid[v] && is_valid_dest(dest_of[v]);
        end
    end

    sa_rr_pick #(.N(NVC), .IW(VCW)) u_first (
        .req   (eligible),
        .ptr   (ptr_q),
        .found (first_found),
        .idx   (vc_a)
    );

    assign a_next = (vc_a == VCW'(NVC - 1)) ? '0 : vc_a + 1'b1;

    always_comb begin
        for (int v = 0; v < NVC; v++) begin
            partner_mask[v] = eligible[v] && vc_short[v]
                              && (dest_of[v] == dest_of[vc_a])
                              && (vc_a != VCW'(v));
        end
    end

    sa_rr_pick #(.N(NVC), .IW(VCW)) u_partner (
        .req   (partner_mask),
        .ptr   (a_next),
        .found (partner_found),
        .idx   (vc_b)
    );

    always_comb begin
        req.dest = dest_of[vc_a];
        if (!first_found) begin
            req.kind = K_NONE;
        end else if (!vc_short[vc_a]) begin
            req.kind = K_LONG;
        end else if (partner_found) begin
            req.kind = K_PAIR;
        end else begin
            req.kind = K_SHORT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (granted && first_found) begin
            ptr_q <= a_next;
        end
    end

    // R1: the offered VC really holds a request
    p_pick_valid_r1: assert property (@(posedge clk) disable iff (rst)
        (req.kind != K_NONE) |-> vc_valid[vc_a]);

    // R2: a paired partner is a distinct short VC with the same destination
    p_pair_match_r2: assert property (@(posedge clk) disable iff (rst)
        (req.kind == K_PAIR) |-> (vc_short[vc_b] && vc_short[vc_a]
                                  && vc_b != vc_a && dest_of[vc_b] == dest_of[vc_a]));

    // R7: pointer only moves on a used grant
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !granted |=> $stable(ptr_q));

endmodule

// File: rtl/sa_output_stage.sv
// Stage 2: primary and short-only secondary arbiters for one output port.
module sa_output_stage
    import sa_pkg::*;
#(
    parameter int NPORT  = SA_NPORT,
    parameter int PW     = SA_PW,
    parameter int VCW    = 1,
    parameter int OUT_ID = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  s1_req_t         reqs  [NPORT],
    input  logic [VCW-1:0]  vca   [NPORT],
    input  logic [VCW-1:0]  vcb   [NPORT],
    output logic            busy,
    output logic            full,
    output logic [PW-1:0]   hi_port,
    output logic [VCW-1:0]  hi_vc,
    output logic            lo_valid,
    output logic [PW-1:0]   lo_port,
    output logic [VCW-1:0]  lo_vc,
    output logic [NPORT-1:0] win_hi,
    output logic [NPORT-1:0] win_lo
);
    logic [NPORT-1:0] prim_mask;
    logic [NPORT-1:0] sec_mask;
    logic [PW-1:0]    pptr_q;
    logic [PW-1:0]    sptr_q;
    logic [PW-1:0]    p_idx;
    logic [PW-1:0]    s_idx;
    logic             p_found;
    logic             s_found;
    logic             use_sec;
    logic             is_pair;

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            prim_mask[i] = (reqs[i].kind != K_NONE) && (reqs[i].dest == PW'(OUT_ID));
        end
    end

    sa_rr_pick #(.N(NPORT), .IW(PW)) u_primary (
        .req   (prim_mask),
        .ptr   (pptr_q),
        .found (p_found),
        .idx   (p_idx)
    );

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            sec_mask[i] = (reqs[i].kind == K_SHORT) && (reqs[i].dest == PW'(OUT_ID))
                          && !(p_found && p_idx == PW'(i));
        end
    end

    sa_rr_pick #(.N(NPORT), .IW(PW)) u_secondary (
        .req   (sec_mask),
        .ptr   (sptr_q),
        .found (s_found),
        .idx   (s_idx)
    );

    always_comb begin
        is_pair  = p_found && (reqs[p_idx].kind == K_PAIR);
        use_sec  = p_found && (reqs[p_idx].kind == K_SHORT) && s_found;
        busy     = p_found;
        full     = p_found && (reqs[p_idx].kind == K_LONG);
        hi_port  = p_idx;
        hi_vc    = vca[p_idx];
        lo_valid = is_pair || use_sec;
        lo_port  = is_pair ? p_idx : s_idx;
        lo_vc    = is_pair ? vcb[p_idx] : vca[s_idx];
        for (int i = 0; i < NPORT; i++) begin
            win_hi[i] = p_found && (p_idx == PW'(i));
            win_lo[i] = use_sec && (s_idx == PW'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pptr_q <= '0;
            sptr_q <= '0;
        end else begin
            if (p_found) begin
                pptr_q <= (p_idx == PW'(NPORT - 1)) ? '0 : p_idx + 1'b1;
            end
            if (use_sec) begin
                sptr_q <= (s_idx == PW'(NPORT - 1)) ? '0 : s_idx + 1'b1;
            end
        end
    end

    // R5: a long winner leaves no room for a lower half
    p_long_whole_r5: assert property (@(posedge clk) disable iff (rst)
        full |-> !lo_valid);

    // R6: the lower half never repeats the upper-half flit
    p_no_double_r6: assert property (@(posedge clk) disable iff (rst)
        (lo_valid && lo_port == hi_port) |-> (lo_vc != hi_vc));

    // R4: a cross-port lower half pairs two single short flits
    p_cross_short_r4: assert property (@(posedge clk) disable iff (rst)
        (lo_valid && lo_port != hi_port) |->
            (reqs[lo_port].kind == K_SHORT && reqs[hi_port].kind == K_SHORT));

    // R11: the winner targets this output
    p_hi_target_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (reqs[hi_port].dest == PW'(OUT_ID)));

    // R7: idle output keeps its primary pointer
    p_pptr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(pptr_q));

endmodule

// File: rtl/sa_pair_alloc.sv
module sa_pair_alloc
    import sa_pkg::*;
#(
    parameter int NVC = 2,
    localparam int VCW   = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int NPORT = SA_NPORT,
    localparam int PW    = SA_PW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPORT*NVC-1:0]    in_valid,
    input  logic [NPORT*NVC*PW-1:0] in_dest,
    input  logic [NPORT*NVC-1:0]    in_short,
    output logic [NPORT*NVC-1:0]    vc_grant,
    output logic [NPORT-1:0]        out_busy,
    output logic [NPORT-1:0]        out_full,
    output logic [NPORT*PW-1:0]     out_hi_port,
    output logic [NPORT*VCW-1:0]    out_hi_vc,
    output logic [NPORT-1:0]        out_lo_valid,
    output logic [NPORT*PW-1:0]     out_lo_port,
    output logic [NPORT*VCW-1:0]    out_lo_vc
);
    s1_req_t          s1     [NPORT];
    logic [VCW-1:0]   s1_a   [NPORT];
    logic [VCW-1:0]   s1_b   [NPORT];
    logic [NPORT-1:0] hi_win [NPORT];
    logic [NPORT-1:0] lo_win [NPORT];
    logic [NPORT-1:0] in_granted;
    logic [NVC-1:0]   vg     [NPORT];

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        sa_input_stage #(.NVC(NVC), .VCW(VCW), .PW(PW)) u_in (
            .clk      (clk),
            .rst      (rst),
            .vc_valid (in_valid[gi*NVC +: NVC]),
            .vc_dest  (in_dest[gi*NVC*PW +: NVC*PW]),
            .vc_short (in_short[gi*NVC +: NVC]),
            .granted  (in_granted[gi]),
            .req      (s1[gi]),
            .vc_a     (s1_a[gi]),
            .vc_b     (s1_b[gi])
        );
    end

    for (genvar go = 0; go < NPORT; go++) begin : g_out
        sa_output_stage #(.NPORT(NPORT), .PW(PW), .VCW(VCW), .OUT_ID(go)) u_out (
            .clk      (clk),
            .rst      (rst),
            .reqs     (s1),
            .vca      (s1_a),
            .vcb      (s1_b),
            .busy     (out_busy[go]),
            .full     (out_full[go]),
            .hi_port  (out_hi_port[go*PW +: PW]),
            .hi_vc    (out_hi_vc[go*VCW +: VCW]),
            .lo_valid (out_lo_valid[go]),
            .lo_port  (out_lo_port[go*PW +: PW]),
            .lo_vc    (out_lo_vc[go*VCW +: VCW]),
            .win_hi   (hi_win[go]),
            .win_lo   (lo_win[go])
        );
    end

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            in_granted[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) begin
                in_granted[i] = in_granted[i] | hi_win[o][i] | lo_win[o][i];
            end
            for (int v = 0; v < NVC; v++) begin
                vg[i][v] = in_granted[i] &&
                           ((s1_a[i] == VCW'(v)) ||
                            (s1[i].kind == K_PAIR && s1_b[i] == VCW'(v)));
            end
        end
    end

    for (genvar gg = 0; gg < NPORT; gg++) begin : g_grant
        assign vc_grant[gg*NVC +: NVC] = vg[gg];
    end

    // R9: grants only reach VCs holding a request
    p_grant_req_r9: assert property (@(posedge clk) disable iff (rst)
        (vc_grant & ~in_valid) == '0);

    // R11: an input appears at most once across all output halves
    for (genvar ga = 0; ga < NPORT; ga++) begin : g_chk
        logic [2*NPORT-1:0] hits;
        always_comb begin
            for (int o = 0; o < NPORT; o++) begin
                hits[2*o]   = hi_win[o][ga];
                hits[2*o+1] = lo_win[o][ga];
            end
        end
        p_one_output_r11: assert property (@(posedge clk) disable iff (rst)
            $onehot0(hits));
    end

endmodule

// File: tb/sim_sa_pair_alloc.sv
`timescale 1ns/1ps
module sim_sa_pair_alloc;
    localparam int NVC = 2;
    localparam int NP  = 5;
    localparam int PW  = 3;
    localparam int VCW = 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NP*NVC-1:0]    in_valid = '0;
    logic [NP*NVC*PW-1:0] in_dest  = '0;
    logic [NP*NVC-1:0]    in_short = '0;
    logic [NP*NVC-1:0]    vc_grant;
    logic [NP-1:0]        out_busy;
    logic [NP-1:0]        out_full;
    logic [NP*PW-1:0]     out_hi_port;
    logic [NP*VCW-1:0]    out_hi_vc;
    logic [NP-1:0]        out_lo_valid;
    logic [NP*PW-1:0]     out_lo_port;
    logic [NP*VCW-1:0]    out_lo_vc;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sa_pair_alloc #(.NVC(NVC)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
        .in_short(in_short), .vc_grant(vc_grant), .out_busy(out_busy),
        .out_full(out_full), .out_hi_port(out_hi_port), .out_hi_vc(out_hi_vc),
        .out_lo_valid(out_lo_valid), .out_lo_port(out_lo_port), .out_lo_vc(out_lo_vc)
    );

    task automatic clear_reqs();
        in_valid = '0;
        in_dest  = '0;
        in_short = '0;
    endtask

    task automatic set_req(int i, int v, int d, bit s);
        in_valid[i*NVC+v] = 1'b1;
        in_dest[(i*NVC+v)*PW +: PW] = PW'(d);
        in_short[i*NVC+v] = s;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clear_reqs();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Check one output: upper half, full flag and lower half
    task automatic chk_out(string tag, int o, bit busy, bit full,
                           int hp, int hv, bit lv, int lp, int lvc);
        bit ok;
        int a_hp, a_hv, a_lp, a_lv;
        a_hp = int'(out_hi_port[o*PW +: PW]);
        a_hv = int'(out_hi_vc[o*VCW +: VCW]);
        a_lp = int'(out_lo_port[o*PW +: PW]);
        a_lv = int'(out_lo_vc[o*VCW +: VCW]);
        ok = (out_busy[o] == busy) && (out_lo_valid[o] == lv);
        if (busy) ok = ok && (out_full[o] == full) && (a_hp == hp) && (a_hv == hv);
        if (lv)   ok = ok && (a_lp == lp) && (a_lv == lvc);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s out%0d: actual busy=%0b full=%0b hi=%0d/%0d lo=%0b %0d/%0d expected busy=%0b full=%0b hi=%0d/%0d lo=%0b %0d/%0d",
                     tag, o, out_busy[o], out_full[o], a_hp, a_hv, out_lo_valid[o], a_lp, a_lv,
                     busy, full, hp, hv, lv, lp, lvc);
        end
    endtask

    task automatic chk_vec(string tag, logic [NP*NVC-1:0] exp_grant, logic [NP-1:0] exp_busy);
        checks++;
        if (vc_grant !== exp_grant || out_busy !== exp_busy) begin
            failures++;
            $display("FAIL %s: actual grant=%b busy=%b expected grant=%b busy=%b",
                     tag, vc_grant, out_busy, exp_grant, exp_busy);
        end
    endtask

    initial begin : watchdog
        #500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        do_reset();

        // R8: idle after reset
        #1;
        chk_vec("R8 idle after reset", '0, '0);
        @(negedge clk);

        // R3 R5 R9 R11: sweep every single request
        for (int i = 0; i < NP; i++) begin
            for (int v = 0; v < NVC; v++) begin
                for (int d = 0; d < NP; d++) begin
                    for (int s = 0; s < 2; s++) begin
                        clear_reqs();
                        set_req(i, v, d, s[0]);
                        #1;
                        chk_out("R5 single request", d, 1, !s[0], i, v, 0, 0, 0);
                        chk_vec("R9 R11 single grant", (NP*NVC)'(1) << (i*NVC+v), NP'(1) << d);
                        @(negedge clk);
                    end
                end
            end
        end

        // R10: destinations 5..7 ignored; another VC still competes
        for (int d = 5; d < 8; d++) begin
            clear_reqs();
            set_req(0, 0, d, 1'b0);
            #1;
            chk_vec("R10 bad dest idle", '0, '0);
            @(negedge clk);
        end
        do_reset();
        set_req(0, 0, 6, 1'b0);
        set_req(0, 1, 2, 1'b0);
        #1;
        chk_out("R10 skip bad dest", 2, 1, 1, 0, 1, 0, 0, 0);
        chk_vec("R10 skip bad dest grant", 10'b00_0000_0010, 5'b00100);

        // R1 R7: short vc0 then long vc1 at input 2
        do_reset();
        set_req(2, 0, 1, 1'b1);
        set_req(2, 1, 1, 1'b0);
        #1;
        chk_out("R1 short pick no partner", 1, 1, 0, 2, 0, 0, 0, 0);
        chk_vec("R1 grant vc0", 10'b00_0001_0000, 5'b00010);
        @(negedge clk);
        chk_out("R1 pointer moved to vc1", 1, 1, 1, 2, 1, 0, 0, 0);
        chk_vec("R1 grant vc1", 10'b00_0010_0000, 5'b00010);

        // R2: same-port pair
        do_reset();
        set_req(2, 0, 1, 1'b1);
        set_req(2, 1, 1, 1'b1);
        #1;
        chk_out("R2 same-port pair", 1, 1, 0, 2, 0, 1, 2, 1);
        chk_vec("R2 pair grant", 10'b00_0011_0000, 5'b00010);

        // R4: cross-port pair
        do_reset();
        set_req(0, 0, 3, 1'b1);
        set_req(4, 1, 3, 1'b1);
        #1;
        chk_out("R4 cross-port pair", 3, 1, 0, 0, 0, 1, 4, 1);
        chk_vec("R4 cross grant", 10'b10_0000_0001, 5'b01000);

        // R5 R3: long blocks short partner, then rotates
        do_reset();
        set_req(0, 0, 3, 1'b0);
        set_req(1, 0, 3, 1'b1);
        #1;
        chk_out("R5 long takes whole", 3, 1, 1, 0, 0, 0, 0, 0);
        chk_vec("R5 long grant only", 10'b00_0000_0001, 5'b01000);
        @(negedge clk);
        chk_out("R3 short after long", 3, 1, 0, 1, 0, 0, 0, 0);
        chk_vec("R3 short grant", 10'b00_0000_0100, 5'b01000);

        // R3: primary rotation over all inputs
        do_reset();
        for (int i = 0; i < NP; i++) set_req(i, 0, 0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            #1;
            chk_out("R3 rotation", 0, 1, 1, k % NP, 0, 0, 0, 0);
            @(negedge clk);
        end

        // R1: stage-1 rotation between VCs of input 1
        do_reset();
        set_req(1, 0, 2, 1'b0);
        set_req(1, 1, 4, 1'b0);
        #1;
        chk_vec("R1 rot c0", 10'b00_0000_0100, 5'b00100);
        @(negedge clk);
        chk_vec("R1 rot c1", 10'b00_0000_1000, 5'b10000);
        @(negedge clk);
        chk_vec("R1 rot c2", 10'b00_0000_0100, 5'b00100);

        // R7: losing input keeps its VC
        do_reset();
        set_req(0, 0, 0, 1'b0);
        set_req(1, 0, 0, 1'b0);
        set_req(1, 1, 2, 1'b0);
        #1;
        chk_vec("R7 loser c0", 10'b00_0000_0001, 5'b00001);
        @(negedge clk);
        chk_out("R7 loser same vc", 0, 1, 1, 1, 0, 0, 0, 0);
        chk_vec("R7 loser c1", 10'b00_0000_0100, 5'b00001);

        // R4 R6: secondary rotation skipping the primary winner
        do_reset();
        set_req(1, 0, 4, 1'b1);
        set_req(2, 0, 4, 1'b1);
        set_req(3, 0, 4, 1'b1);
        #1;
        chk_out("R4 R6 sec c0", 4, 1, 0, 1, 0, 1, 2, 0);
        chk_vec("R4 sec grant c0", 10'b00_0001_0100, 5'b10000);
        @(negedge clk);
        chk_out("R4 R6 sec c1", 4, 1, 0, 2, 0, 1, 3, 0);
        chk_vec("R4 sec grant c1", 10'b00_0101_0000, 5'b10000);
        @(negedge clk);
        chk_out("R4 R6 sec wrap c2", 4, 1, 0, 3, 0, 1, 1, 0);
        chk_vec("R4 sec grant c2", 10'b00_0100_0100, 5'b10000);

        // R2 R6: pair winner shuts out cross-port partner
        do_reset();
        set_req(0, 0, 1, 1'b1);
        set_req(0, 1, 1, 1'b1);
        set_req(3, 0, 1, 1'b1);
        #1;
        chk_out("R2 R6 pair over partner", 1, 1, 0, 0, 0, 1, 0, 1);
        chk_vec("R2 pair only grant", 10'b00_0000_0011, 5'b00010);

        // R8: reset restores pointers to index 0
        @(negedge clk);
        do_reset();
        set_req(0, 0, 1, 1'b1);
        set_req(0, 1, 1, 1'b1);
        set_req(3, 0, 1, 1'b1);
        #1;
        chk_out("R8 pointers cleared", 1, 1, 0, 0, 0, 1, 0, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule